// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table of segment descriptors. Each slot holds two 64-bit words. The segment-key word carries the effective segment number and a valid flag. The descriptor word carries the virtual segment data and a two-bit segment-size code in its top bits. A combinational port answers translation queries. It reports whether an effective address falls in a stored segment, which slot matched, and that slot's descriptor word.

A single command port, one command per cycle, changes or inspects the table. The commands are: write a slot, read either word of a slot, drop every slot except slot 0, and drop the slot that covers a given address. Writes and reads are checked against the implemented slot count, and writes are also checked against the size code and the configured support for large segments. A rejected command raises a one-cycle error flag. Any drop that actually removes a valid slot raises a one-cycle pulse that tells downstream translation caches to flush everything.

Top module: `slb_array`

## Requirements
- R1: A lookup is combinational. `lk_hit` is 1 when a slot with size code 00 holds a key word equal to `{lk_ea[63:28], 1'b1, 27'b0}`. `lk_slot` then gives that slot and `lk_vsid` its descriptor word. On a miss, `lk_slot` and `lk_vsid` read 0.
- R2: A slot with size code 01 matches when its key word equals `{lk_ea[63:40], 12'b0, 1'b1, 27'b0}`. A slot never matches under the other size's key.
- R3: When several slots match, the lowest-numbered slot is reported.
- R4: Command codes on `op_code` are: 0 idle, 1 write, 2 read key word, 3 read descriptor word, 4 drop all, 5 drop by address. The slot number is `op_rb[11:0]`. A legal write stores `op_rb` with bits 26:0 cleared as the key word, and `op_rs` unchanged as the descriptor. A read returns the addressed word on `rd_data` after the next rising edge. `rd_data` holds its value otherwise.
- R5: A write with `op_rb[11:0]` at or above the slot count (64) changes nothing and pulses `op_err` for one cycle.
- R6: A write whose `op_rs[63]` is 1 (size code 10 or 11) changes nothing and pulses `op_err`.
- R7: A write with size code 01 while `seg1t_en` is 0 changes nothing and pulses `op_err`.
- R8: A read of either word with a slot number at or above 64 pulses `op_err` and sets `rd_data` to 0.
- R9: Drop-all clears the valid bit (bit 27) of slots 1 to 63 and leaves slot 0 untouched. `tlb_flush` pulses only if at least one of those slots was valid.
- R10: Drop-by-address looks up `op_rb` as an effective address. On a hit it clears that slot's valid bit and pulses `tlb_flush`. On a miss nothing changes and there is no pulse.
- R11: After reset, every slot word is 0, no lookup hits, and `rd_data`, `op_err` and `tlb_flush` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| seg1t_en | input | 1 | 1 when large (1 TB) segments may be written |
| lk_ea | input | 64 | Effective address to look up |
| lk_hit | output | 1 | Lookup found a valid matching slot |
| lk_slot | output | 6 | Index of the matching slot |
| lk_vsid | output | 64 | Descriptor word of the matching slot |
| op_valid | input | 1 | A command is presented this cycle |
| op_code | input | 3 | Command code |
| op_rb | input | 64 | Key operand / slot number / drop address |
| op_rs | input | 64 | Descriptor operand for writes |
| rd_data | output | 64 | Word returned by the last read |
| op_err | output | 1 | One-cycle pulse: rejected write or read |
| tlb_flush | output | 1 | One-cycle pulse: a valid slot was dropped |

## Verification
Lookup results have no register on their path. The bench samples them one time unit after driving `lk_ea`, in the same cycle, against a behavioural table held in the bench. Command results (`rd_data`, `op_err`, `tlb_flush`) come from one register stage. They are compared at the falling edge after the rising edge that accepted the command. By then the bench's table has already applied that command. Lookups issued in the following command cycle therefore show the new table contents. The bench also confirms that a rejected or missed command left the table unchanged.

// File: rtl/slb_pkg.sv
// Shared constants and command encoding for the segment lookaside array.
// Assumes 64-bit words; bit positions are fixed by the entry format.
package slb_pkg;

    localparam int VBIT      = 27;  // valid flag in the key word
    localparam int SEG_S_LSB = 28;  // lowest key bit of a small segment
    localparam int SEG_L_LSB = 40;  // lowest key bit of a large segment
    localparam int SLOTW     = 12;  // slot field width in the rb operand

    localparam logic [1:0] SZ_SMALL = 2'b00;
    localparam logic [1:0] SZ_LARGE = 2'b01;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_RDKEY = 3'd2,
        OP_RDDSC = 3'd3,
        OP_DRALL = 3'd4,
        OP_DRADR = 3'd5
    } slb_op_e;

endpackage

// File: rtl/slb_match.sv
// Associative matcher: compares an effective address against every slot
// under both segment sizes and reports the lowest matching slot.
// Assumes key words were stored with bits below the valid flag cleared.
module slb_match
    import slb_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SLOTS = 64,
    parameter int IDXW  = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0][XLEN-1:0] key_q,
    input  logic [SLOTS-1:0][XLEN-1:0] dsc_q,
    input  logic [XLEN-1:0]            ea,
    output logic                       hit,
    output logic [IDXW-1:0]            idx,
    output logic [XLEN-1:0]            dsc
);

    localparam logic [XLEN-1:0] VMASK = XLEN'(1) << VBIT;
    localparam logic [XLEN-1:0] SMASK = {{(XLEN-SEG_S_LSB){1'b1}}, {SEG_S_LSB{1'b0}}};
    localparam logic [XLEN-1:0] LMASK = {{(XLEN-SEG_L_LSB){1'b1}}, {SEG_L_LSB{1'b0}}};

    logic [XLEN-1:0]  key_s;
    logic [XLEN-1:0]  key_l;
    logic [SLOTS-1:0] m;

    // Form the two candidate keys from the address
    always_comb begin
        key_s = (ea & SMASK) | VMASK;
        key_l = (ea & LMASK) | VMASK;
    end

    // One comparator pair per slot, qualified by the slot's size code
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign m[g] = ((key_q[g] == key_s) && (dsc_q[g][XLEN-1 -: 2] == SZ_SMALL)) ||
                      ((key_q[g] == key_l) && (dsc_q[g][XLEN-1 -: 2] == SZ_LARGE));
    end

    // Priority pick: scan downward so the lowest index is kept
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (m[i]) begin
                hit = 1'b1;
                idx = IDXW'(i);
            end
        end
        dsc = hit ? dsc_q[idx] : '0;
    end

endmodule

// File: rtl/slb_arg_check.sv
// Operand legality for write and read commands.
// Assumes the slot field is the low SLOTW bits of rb and the size code
// is the top two bits of rs.
module slb_arg_check
    import slb_pkg::*;
#(
    parameter int SLOTS = 64,
    parameter int IDXW  = $clog2(SLOTS)
) (
    input  logic [SLOTW-1:0] rb_slot,
    input  logic [1:0]       rs_size,
    input  logic             seg1t_en,
    output logic [IDXW-1:0]  slot_idx,
    output logic             slot_ok,
    output logic             size_ok
);

    // Range check on the slot field and size-code screening
    always_comb begin
        slot_idx = rb_slot[IDXW-1:0];
        slot_ok  = (rb_slot < SLOTW'(SLOTS));
        size_ok  = (rs_size == SZ_SMALL) || ((rs_size == SZ_LARGE) && seg1t_en);
    end

endmodule

// File: rtl/slb_store.sv
// Slot storage: per-slot registers with a single write port and a
// per-slot valid-clear mask. Write has priority over clear for a slot.
module slb_store
    import slb_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SLOTS = 64,
    parameter int IDXW  = $clog2(SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDXW-1:0]            wr_idx,
    input  logic [XLEN-1:0]            wr_key,
    input  logic [XLEN-1:0]            wr_dsc,
    input  logic [SLOTS-1:0]           clr_mask,
    output logic [SLOTS-1:0][XLEN-1:0] key_q,
    output logic [SLOTS-1:0][XLEN-1:0] dsc_q
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Hold, load or drop one slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_q[g] <= '0;
                dsc_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDXW'(g))) begin
                key_q[g] <= wr_key;
                dsc_q[g] <= wr_dsc;
            end else if (clr_mask[g]) begin
                key_q[g][VBIT] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/slb_array.sv
// Top of the segment lookaside array: combinational lookup port plus a
// one-command-per-cycle port for write, read and drop commands.
// Assumes the caller holds op_valid low when no command is presented.
module slb_array
    import slb_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SLOTS = 64,
    localparam int IDXW = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seg1t_en,
    input  logic [XLEN-1:0] lk_ea,
    output logic            lk_hit,
    output logic [IDXW-1:0] lk_slot,
    output logic [XLEN-1:0] lk_vsid,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [XLEN-1:0] op_rb,
    input  logic [XLEN-1:0] op_rs,
    output logic [XLEN-1:0] rd_data,
    output logic            op_err,
    output logic            tlb_flush
);

    localparam logic [XLEN-1:0] KEEP = {{(XLEN-VBIT){1'b1}}, {VBIT{1'b0}}};

    logic [SLOTS-1:0][XLEN-1:0] key_q;
    logic [SLOTS-1:0][XLEN-1:0] dsc_q;
    logic [SLOTS-1:0]           valid;
    logic [IDXW-1:0]            slot_idx;
    logic                       slot_ok;
    logic                       size_ok;
    logic                       dr_hit;
    logic [IDXW-1:0]            dr_idx;
    logic [XLEN-1:0]            dr_dsc;
    logic                       wr_en;
    logic [SLOTS-1:0]           clr_mask;
    logic                       err_d;
    logic                       flush_d;
    logic                       rd_upd;
    logic [XLEN-1:0]            rd_d;
    slb_op_e                    op;

    assign op = slb_op_e'(op_code);

    for (genvar g = 0; g < SLOTS; g++) begin : g_valid
        assign valid[g] = key_q[g][VBIT];
    end

    slb_store #(.XLEN(XLEN), .SLOTS(SLOTS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (slot_idx),
        .wr_key   (op_rb & KEEP),
        .wr_dsc   (op_rs),
        .clr_mask (clr_mask),
        .key_q    (key_q),
        .dsc_q    (dsc_q)
    );

    slb_arg_check #(.SLOTS(SLOTS)) u_chk_args (
        .rb_slot  (op_rb[SLOTW-1:0]),
        .rs_size  (op_rs[XLEN-1 -: 2]),
        .seg1t_en (seg1t_en),
        .slot_idx (slot_idx),
        .slot_ok  (slot_ok),
        .size_ok  (size_ok)
    );

    // Translation-query matcher
    slb_match #(.XLEN(XLEN), .SLOTS(SLOTS)) u_lk (
        .key_q (key_q),
        .dsc_q (dsc_q),
        .ea    (lk_ea),
        .hit   (lk_hit),
        .idx   (lk_slot),
        .dsc   (lk_vsid)
    );

    // Matcher for drop-by-address, fed from the command operand
    slb_match #(.XLEN(XLEN), .SLOTS(SLOTS)) u_dr (
        .key_q (key_q),
        .dsc_q (dsc_q),
        .ea    (op_rb),
        .hit   (dr_hit),
        .idx   (dr_idx),
        .dsc   (dr_dsc)
    );

    // Decode the command into storage controls and next output values
    always_comb begin
        wr_en    = 1'b0;
        clr_mask = '0;
        err_d    = 1'b0;
        flush_d  = 1'b0;
        rd_upd   = 1'b0;
        rd_d     = '0;
        if (op_valid) begin
            unique case (op)
                OP_WRITE: begin
                    wr_en = slot_ok && size_ok;
                    err_d = !(slot_ok && size_ok);
                end
                OP_RDKEY, OP_RDDSC: begin
                    rd_upd = 1'b1;
                    err_d  = !slot_ok;
                    if (slot_ok) begin
                        rd_d = (op == OP_RDKEY) ? key_q[slot_idx] : dsc_q[slot_idx];
                    end
                end
                OP_DRALL: begin
                    clr_mask = valid & ~SLOTS'(1);
                    flush_d  = |clr_mask;
                end
                OP_DRADR: begin
                    if (dr_hit) begin
                        clr_mask = SLOTS'(1) << dr_idx;
                        flush_d  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register the command results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            op_err    <= 1'b0;
            tlb_flush <= 1'b0;
        end else begin
            op_err    <= err_d;
            tlb_flush <= flush_d;
            if (rd_upd) begin
                rd_data <= rd_d;
            end
        end
    end

    logic unused_dr;
    assign unused_dr = ^dr_dsc;

endmodule

// File: rtl/slb_array_chk.sv
// Property checker for slb_array, attached through bind. Observes ports only.
module slb_array_chk #(
    parameter int XLEN  = 64,
    parameter int SLOTS = 64,
    localparam int IDXW = $clog2(SLOTS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            seg1t_en,
    input logic [XLEN-1:0] lk_ea,
    input logic            lk_hit,
    input logic [IDXW-1:0] lk_slot,
    input logic [XLEN-1:0] lk_vsid,
    input logic            op_valid,
    input logic [2:0]      op_code,
    input logic [XLEN-1:0] op_rb,
    input logic [XLEN-1:0] op_rs,
    input logic [XLEN-1:0] rd_data,
    input logic            op_err,
    input logic            tlb_flush
);

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_slot == '0 && lk_vsid == '0)); // R1

    AST_HIT_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> !lk_vsid[XLEN-1]); // R2

    AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1 && op_rs[XLEN-1]) |=> op_err); // R6

    AST_NO_LARGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1 && op_rs[XLEN-1 -: 2] == 2'b01 && !seg1t_en) |=> op_err); // R7

    AST_READ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 3'd2 || op_code == 3'd3) && op_rb[11:0] >= 12'(SLOTS))
        |=> (op_err && rd_data == '0)); // R8

    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_err) |-> $past(op_valid && op_code >= 3'd1 && op_code <= 3'd3)); // R5

    AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tlb_flush) |-> $past(op_valid && (op_code == 3'd4 || op_code == 3'd5))); // R9 R10

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || (op_code != 3'd2 && op_code != 3'd3)) |=> $stable(rd_data)); // R4

    logic unused_lk;
    assign unused_lk = ^lk_ea;

endmodule

bind slb_array slb_array_chk #(.XLEN(XLEN), .SLOTS(SLOTS)) u_slb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg1t_en  (seg1t_en),
    .lk_ea     (lk_ea),
    .lk_hit    (lk_hit),
    .lk_slot   (lk_slot),
    .lk_vsid   (lk_vsid),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_rb     (op_rb),
    .op_rs     (op_rs),
    .rd_data   (rd_data),
    .op_err    (op_err),
    .tlb_flush (tlb_flush)
);

// File: tb/sim_slb_array.sv
`timescale 1ns/1ps
module sim_slb_array;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg1t_en = 1'b1;
    logic [63:0] lk_ea = '0;
    logic        lk_hit;
    logic [5:0]  lk_slot;
    logic [63:0] lk_vsid;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [63:0] op_rb = '0;
    logic [63:0] op_rs = '0;
    logic [63:0] rd_data;
    logic        op_err;
    logic        tlb_flush;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [63:0] m_key [64];
    logic [63:0] m_dsc [64];
    logic [63:0] m_rd;
    bit          m_err, m_flush;

    always #2.5 clk = ~clk;

    slb_array u0 (
        .clk(clk), .rst_n(rst_n), .seg1t_en(seg1t_en),
        .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_vsid(lk_vsid),
        .op_valid(op_valid), .op_code(op_code), .op_rb(op_rb), .op_rs(op_rs),
        .rd_data(rd_data), .op_err(op_err), .tlb_flush(tlb_flush)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference lookup: scan the table by index, first match wins
    task automatic ref_lookup(input logic [63:0] ea, output bit hit, output int idx, output logic [63:0] d);
        hit = 0; idx = 0; d = '0;
        for (int i = 0; i < 64; i++) begin
            logic [63:0] ks, kl;
            ks = {ea[63:28], 28'h800_0000};
            kl = {ea[63:40], 40'h00_0800_0000};
            if (!hit && ((m_key[i] == ks && m_dsc[i][63:62] == 2'b00) ||
                         (m_key[i] == kl && m_dsc[i][63:62] == 2'b01))) begin
                hit = 1; idx = i; d = m_dsc[i];
            end
        end
    endtask

    task automatic ref_apply(input logic [2:0] code, input logic [63:0] rb, input logic [63:0] rs);
        int s;
        bit h;
        int ix;
        logic [63:0] dd;
        s = int'(rb[11:0]);
        m_err = 0; m_flush = 0;
        case (code)
            3'd1: begin
                if (s >= 64 || rs[63] || (rs[63:62] == 2'b01 && !seg1t_en)) m_err = 1;
                else begin
                    m_key[s] = {rb[63:27], 27'b0};
                    m_dsc[s] = rs;
                end
            end
            3'd2, 3'd3: begin
                if (s >= 64) begin m_err = 1; m_rd = '0; end
                else m_rd = (code == 3'd2) ? m_key[s] : m_dsc[s];
            end
            3'd4: begin
                for (int i = 1; i < 64; i++) begin
                    if (m_key[i][27]) begin m_flush = 1; m_key[i][27] = 1'b0; end
                end
            end
            3'd5: begin
                ref_lookup(rb, h, ix, dd);
                if (h) begin m_key[ix][27] = 1'b0; m_flush = 1; end
            end
            default: ;
        endcase
    endtask

    // One command cycle: lookup checked in-cycle, command results one edge later
    task automatic step(input string tag, input logic [2:0] code, input logic [63:0] rb,
                        input logic [63:0] rs, input logic [63:0] ea);
        bit h;
        int ix;
        logic [63:0] dd;
        @(negedge clk);
        op_valid = (code != 3'd0);
        op_code = code; op_rb = rb; op_rs = rs; lk_ea = ea;
        #1;
        ref_lookup(ea, h, ix, dd);
        chk(tag, "lk_hit", {63'b0, lk_hit}, {63'b0, h});
        chk(tag, "lk_slot", {58'b0, lk_slot}, 64'(ix));
        chk(tag, "lk_vsid", lk_vsid, dd);
        @(posedge clk);
        ref_apply(code, rb, rs);
        @(negedge clk);
        chk(tag, "rd_data", rd_data, m_rd);
        chk(tag, "op_err", {63'b0, op_err}, {63'b0, m_err});
        chk(tag, "tlb_flush", {63'b0, tlb_flush}, {63'b0, m_flush});
        op_valid = 1'b0; op_code = '0;
    endtask

    function automatic logic [63:0] rbs(input logic [35:0] seg, input bit v, input logic [11:0] slot);
        return {seg, v, 15'b0, slot};
    endfunction

    function automatic logic [63:0] rbl(input logic [23:0] seg, input bit v, input logic [11:0] slot);
        return {seg, 12'b0, v, 15'b0, slot};
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) begin m_key[i] = '0; m_dsc[i] = '0; end
        m_rd = '0; m_err = 0; m_flush = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11", "rd_data", rd_data, 64'h0);
        chk("R11", "op_err", {63'b0, op_err}, 64'h0);
        chk("R11", "tlb_flush", {63'b0, tlb_flush}, 64'h0);
        step("R11", 3'd2, 64'd5, 64'h0, 64'h0000_0000_0800_0000);
        step("R11", 3'd3, 64'd63, 64'h0, 64'h0);

        // R4: writes with junk below the valid flag, readback
        step("R4", 3'd1, rbs(36'h123, 1, 12'd3) | 64'h0010_0000, 64'h0000_0000_00AB_CDEF, 64'h0);
        step("R4", 3'd2, 64'd3, 64'h0, 64'h0);
        step("R4", 3'd3, 64'd3, 64'h0, 64'h0);
        step("R4", 3'd1, rbs(36'h777, 1, 12'd0), 64'h0000_1111_2222_3333, 64'h0);
        // R1: small-segment hits and misses
        step("R1", 3'd0, 64'h0, 64'h0, {36'h123, 28'h456_789A});
        step("R1", 3'd0, 64'h0, 64'h0, {36'h124, 28'h0});
        step("R1", 3'd0, 64'h0, 64'h0, {36'h777, 28'hFFF_FFFF});
        // stored without valid flag: never matches
        step("R1", 3'd1, rbs(36'h999, 0, 12'd9), 64'h5, {36'h999, 28'h0});
        step("R1", 3'd0, 64'h0, 64'h0, {36'h999, 28'h0});

        // R2: large segments
        step("R2", 3'd1, rbl(24'h5, 1, 12'd7), 64'h4000_0000_0000_0077, 64'h0);
        step("R2", 3'd0, 64'h0, 64'h0, {24'h5, 40'h32_1000_0000});
        step("R2", 3'd1, rbl(24'h6, 1, 12'd12), 64'h0000_0000_0000_0066, 64'h0);
        step("R2", 3'd0, 64'h0, 64'h0, {24'h6, 40'h00_0000_0000});
        // R3: lower slot wins
        step("R3", 3'd1, rbl(24'h5, 1, 12'd2), 64'h4000_0000_0000_0022, {24'h5, 40'h1});
        step("R3", 3'd0, 64'h0, 64'h0, {24'h5, 40'hFF_FFFF_FFFF});
        step("R3", 3'd1, rbs(36'h123, 1, 12'd40), 64'h0000_0000_0000_4040, 64'h0);
        step("R3", 3'd0, 64'h0, 64'h0, {36'h123, 28'h0});

        // R5: slot out of range
        step("R5", 3'd1, rbs(36'h123, 1, 12'd64), 64'hDEAD, {36'h123, 28'h0});
        step("R5", 3'd1, rbs(36'h123, 1, 12'h800), 64'hDEAD, {36'h123, 28'h0});
        step("R5", 3'd3, 64'd0, 64'h0, 64'h0);
        // R6: bad size code
        step("R6", 3'd1, rbs(36'h321, 1, 12'd3), 64'h8000_0000_0000_0001, 64'h0);
        step("R6", 3'd1, rbs(36'h321, 1, 12'd3), 64'hC000_0000_0000_0001, {36'h321, 28'h0});
        step("R6", 3'd3, 64'd3, 64'h0, 64'h0);
        // R7: large segment disallowed
        seg1t_en = 1'b0;
        step("R7", 3'd1, rbl(24'h9, 1, 12'd4), 64'h4000_0000_0000_0004, 64'h0);
        step("R7", 3'd0, 64'h0, 64'h0, {24'h9, 40'h0});
        step("R7", 3'd1, rbs(36'hABC, 1, 12'd4), 64'h0000_0000_0000_0004, {24'h9, 40'h0});
        seg1t_en = 1'b1;
        // R8: reads out of range
        step("R8", 3'd2, 64'd100, 64'h0, 64'h0);
        step("R8", 3'd3, 64'd3, 64'h0, 64'h0);
        step("R8", 3'd3, 64'hFFF, 64'h0, 64'h0);

        // R10: drop by address
        step("R10", 3'd5, {36'h555, 28'h0}, 64'h0, {36'h123, 28'h0});
        step("R10", 3'd5, {36'h123, 28'h1234}, 64'h0, {36'h123, 28'h0});
        step("R10", 3'd0, 64'h0, 64'h0, {36'h123, 28'h0});
        step("R10", 3'd5, {36'h123, 28'h0}, 64'h0, {36'h123, 28'h0});
        step("R10", 3'd5, {36'h123, 28'h0}, 64'h0, {36'h123, 28'h0});
        step("R10", 3'd5, {36'h777, 28'h0}, 64'h0, {36'h777, 28'h0});
        step("R10", 3'd1, rbs(36'h777, 1, 12'd0), 64'h0000_1111_2222_3333, {36'h777, 28'h0});

        // R9: drop all spares slot 0
        step("R9", 3'd4, 64'h0, 64'h0, {36'h777, 28'h0});
        step("R9", 3'd0, 64'h0, 64'h0, {24'h5, 40'h0});
        step("R9", 3'd0, 64'h0, 64'h0, {36'h777, 28'h0});
        step("R9", 3'd4, 64'h0, 64'h0, {36'h777, 28'h0});
        step("R9", 3'd2, 64'd7, 64'h0, 64'h0);
        step("R9", 3'd2, 64'd0, 64'h0, 64'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule